// File: doc/BRIEF.md
# EEPROM Write Unlock Controller

This block sits between a processor-style register bus and a small on-chip byte array that models data EEPROM. Software loads an address (split over a low and a high byte register), a data byte and a control register. It then writes a two-byte key to a dedicated key register and sets the start bit. The controller checks the key sequence, the enable bit, the region field, the power-up lockout, the protection inputs and the address range. It then either runs a timed write or refuses the request.

A refused request on protection or address grounds leaves the start bit clear, leaves the array untouched and sets a sticky error flag. A request that lacks the key, the enable bit, the region or an expired lockout is dropped with no error. An accepted write keeps the start bit high while it runs and clears it when the byte lands, so software polls the start bit. Erasing a byte means writing 0xFF to it through the same path.

Top module: `ee_wr_guard`

## Requirements
- R1: After reset every register reads 0: the address bytes (sel 0 = low, sel 1 = high), the data read (sel 2) with region 00, and the control register (sel 3). Control bits are start = bit 0, enable = bit 1, error = bit 2, region = bits 5:4, and all other bits read 0.
- R2: A write starts only when the bus write that sets start (sel 3, bit 0 = 1) directly follows a write of 0x55 and then a write of 0xAA to the key register (sel 4), with no other bus write between them. Idle cycles without a bus write do not break the sequence. Otherwise start stays 0.
- R3: Any bus write after the 0x55 other than 0xAA to the key register returns the sequence to its initial state. This covers a write to another register or a wrong key value, and a later start request is then ignored.
- R4: A start request is ignored unless the enable bit was already 1 in the control register before the start write.
- R5: For PWRT_CYCLES clock cycles after reset, start requests are ignored.
- R6: If wr_prot or code_prot is high, or the address {high,low} is 0x400 or above (DEPTH), an otherwise valid start request leaves start at 0, changes no array byte and sets the error bit. Address 0x3FF is valid.
- R7: The error bit stays set until a control write with bit 2 = 0. Writing 1 to it has no effect, and a successful write does not clear it.
- R8: An accepted start keeps bit 0 at 1 for exactly WRITE_CYCLES clock cycles after the start write. It then clears, and the array byte at the address holds the data register value (0xFF included).
- R9: While a write runs, bus writes to the address and data registers are ignored.
- R10: A data read (sel 2) returns 0x00 while code_prot is high, the region field is not 01, or the address is out of range. Otherwise it returns the array byte at the address.
- R11: A start request is ignored, with no error, unless the region field already held 01 before the start write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_sel | input | 3 | Register select: 0 addr low, 1 addr high, 2 data, 3 control, 4 key |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| wr_prot | input | 1 | Array write-protect |
| code_prot | input | 1 | Code protection; blocks array reads and writes |

## Verification
The bench breaks the key sequence in several ways: a foreign register write between the two bytes, a wrong second byte, and an unrelated write after arming. A controller that only remembered having seen both bytes at some point would start a write in each case. It aims an invalid address of 0x400 whose low bits alias a written byte. A design that truncated the address instead of range-checking it would corrupt location 0. It measures the exact busy length, rewrites address and data mid-write, and checks that a successful write leaves a pending error set. Designs that were off by one, let the target drift, or cleared the flag on success would show the wrong count, the wrong byte or a cleared error.

// File: rtl/ee_wr_guard_pkg.sv
package ee_wr_guard_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_ADRL = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ADRH = 3'd1;
  localparam logic [SEL_W-1:0] SEL_DATA = 3'd2;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd3;
  localparam logic [SEL_W-1:0] SEL_KEY  = 3'd4;

  localparam int CB_START = 0;
  localparam int CB_WEN   = 1;
  localparam int CB_ERR   = 2;
  localparam int CB_RGN   = 4;

  localparam logic [1:0]        RGN_EE = 2'b01;
  localparam logic [DATA_W-1:0] KEY_1  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_2  = 8'hAA;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } ul_state_e;
endpackage

// File: rtl/ee_unlock_fsm.sv
module ee_unlock_fsm
  import ee_wr_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              armed
);

  ul_state_e st_q, st_d;
  logic      key_wr;

  assign key_wr = bus_we && (bus_sel == SEL_KEY);

  always_comb begin
    st_d = st_q;
    if (bus_we) begin
      if (key_wr && (bus_wdata == KEY_1))
        st_d = UL_HALF;
      else if ((st_q == UL_HALF) && key_wr && (bus_wdata == KEY_2))
        st_d = UL_ARMED;
      else
        st_d = UL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UL_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == UL_ARMED);

  // R2: arming is consumed by the very next bus write
  a_r2_arm_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bus_we) |=> !armed);

  // R3: arming only follows a 0xAA key write made while half-way
  a_r3_arm_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(st_q == UL_HALF && key_wr && bus_wdata == KEY_2));

endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (!busy_q) begin
      if (launch) begin
        busy_d = 1'b1;
        cnt_d  = CNT_W'(CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  // R8: countdown never exceeds the programmed length
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CNT_W'(CYCLES)));

  // R8: completion ends the busy phase on the next edge
  a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);

endmodule

// File: rtl/ee_byte_array.sv
module ee_byte_array #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ee_wr_guard.sv
module ee_wr_guard
  import ee_wr_guard_pkg::*;
#(
  parameter int DEPTH        = 1024,
  parameter int WRITE_CYCLES = 16,
  parameter int PWRT_CYCLES  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wr_prot,
  input  logic              code_prot
);
  localparam int MEM_AW = $clog2(DEPTH);
  localparam int FA_W   = 2 * DATA_W;
  localparam int PW_W   = $clog2(PWRT_CYCLES + 1);
  localparam logic [FA_W:0] DEPTH_V = (FA_W + 1)'(DEPTH);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  // state
  logic [DATA_W-1:0] adr_lo_q, adr_lo_d, adr_hi_q, adr_hi_d, dat_q, dat_d;
  logic              wen_q, wen_d, err_q, err_d;
  logic [1:0]        rgn_q, rgn_d;
  logic [PW_W-1:0]   pwrt_cnt_q, pwrt_cnt_d;

  logic              armed, busy, done;
  logic [FA_W-1:0]   full_addr;
  logic              addr_ok, pwrt_done, ctrl_wr, start_req, go_ok, fault;
  logic              launch, err_set;
  logic [DATA_W-1:0] mem_rdata;

  ee_unlock_fsm u_unlock (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .armed     (armed)
  );

  ee_wr_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .launch (launch),
    .busy   (busy),
    .done   (done)
  );

  ee_byte_array #(.DEPTH(DEPTH), .DW(DATA_W), .AW(MEM_AW)) u_array (
    .clk   (clk),
    .we    (done),
    .waddr (full_addr[MEM_AW-1:0]),
    .wdata (dat_q),
    .raddr (full_addr[MEM_AW-1:0]),
    .rdata (mem_rdata)
  );

  // request qualification
  assign full_addr = {adr_hi_q, adr_lo_q};
  assign addr_ok   = {1'b0, full_addr} < DEPTH_V;
  assign pwrt_done = (pwrt_cnt_q == PW_W'(PWRT_CYCLES));
  assign ctrl_wr   = bus_we && (bus_sel == SEL_CTRL);
  assign start_req = ctrl_wr && bus_wdata[CB_START] && armed;
  assign go_ok     = start_req && !busy && pwrt_done && wen_q && (rgn_q == RGN_EE);
  assign fault     = wr_prot || code_prot || !addr_ok;
  assign launch    = go_ok && !fault;
  assign err_set   = go_ok && fault;

  // next state
  always_comb begin
    adr_lo_d   = adr_lo_q;
    adr_hi_d   = adr_hi_q;
    dat_d      = dat_q;
    wen_d      = wen_q;
    rgn_d      = rgn_q;
    err_d      = err_q;
    pwrt_cnt_d = pwrt_done ? pwrt_cnt_q : pwrt_cnt_q + 1'b1;

    if (bus_we && !busy) begin
      case (bus_sel)
        SEL_ADRL: adr_lo_d = bus_wdata;
        SEL_ADRH: adr_hi_d = bus_wdata;
        SEL_DATA: dat_d    = bus_wdata;
        default:  ;
      endcase
    end

    if (ctrl_wr) begin
      wen_d = bus_wdata[CB_WEN];
      if (!busy) rgn_d = bus_wdata[CB_RGN +: 2];
      if (!bus_wdata[CB_ERR]) err_d = 1'b0;
    end
    if (err_set) err_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      adr_lo_q   <= '0;
      adr_hi_q   <= '0;
      dat_q      <= '0;
      wen_q      <= 1'b0;
      rgn_q      <= 2'b00;
      err_q      <= 1'b0;
      pwrt_cnt_q <= '0;
    end else begin
      adr_lo_q   <= adr_lo_d;
      adr_hi_q   <= adr_hi_d;
      dat_q      <= dat_d;
      wen_q      <= wen_d;
      rgn_q      <= rgn_d;
      err_q      <= err_d;
      pwrt_cnt_q <= pwrt_cnt_d;
    end
  end

  // read path
  always_comb begin
    case (bus_sel)
      SEL_ADRL: bus_rdata = adr_lo_q;
      SEL_ADRH: bus_rdata = adr_hi_q;
      SEL_DATA: bus_rdata = (!code_prot && (rgn_q == RGN_EE) && addr_ok) ? mem_rdata : '0;
      SEL_CTRL: bus_rdata = {2'b00, rgn_q, 1'b0, err_q, wen_q, busy};
      default:  bus_rdata = '0;
    endcase
  end

  // R2: a write can only begin from the armed state
  a_r2_needs_arm: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(busy) |-> $past(armed));

  // R4: enable bit must already be set
  a_r4_needs_wen: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(busy) |-> $past(wen_q));

  // R5: nothing runs during the power-up lockout
  a_r5_lockout: assert property (@(posedge clk) disable iff (!rst_s_n)
    !pwrt_done |-> !busy);

  // R6: a refusal never coincides with a launch
  a_r6_fault_no_launch: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(err_q) |-> !$rose(busy));

  // R7: the error flag falls only after a control write of 0 to it
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(err_q) |-> $past(ctrl_wr && !bus_wdata[CB_ERR]));

  // R9: target address and data hold while a write runs
  a_r9_target_frozen: assert property (@(posedge clk) disable iff (!rst_s_n)
    $past(busy) |-> $stable({adr_hi_q, adr_lo_q, dat_q}));

  // R10: protected reads return zero
  a_r10_read_blocked: assert property (@(posedge clk) disable iff (!rst_s_n)
    (code_prot && bus_sel == SEL_DATA) |-> (bus_rdata == '0));

  // R11: region field must select the array
  a_r11_region: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(busy) |-> $past(rgn_q == RGN_EE));

endmodule

// File: tb/ee_wr_guard_tb_top.sv
module ee_wr_guard_tb_top;
  localparam int WC = 16;
  localparam int PW = 64;
  localparam int NV = 58;

  // vector: {req, op, sel, data}; op 0 = write, 1 = read check, 2 = poll start clear
  localparam logic [31:0] VEC [NV] = '{
    // R8 basic write of 0xA5 to 0x000 (R2 key sequence)
    32'h08_00_03_12, 32'h08_00_00_00, 32'h08_00_01_00, 32'h08_00_02_A5,
    32'h02_00_04_55, 32'h02_00_04_AA, 32'h02_00_03_13, 32'h08_01_03_13,
    32'h08_02_03_00, 32'h08_01_02_A5,
    // R8 erase with 0xFF
    32'h08_00_02_FF, 32'h08_00_04_55, 32'h08_00_04_AA, 32'h08_00_03_13,
    32'h08_02_03_00, 32'h08_01_02_FF,
    // R6 last valid address 0x3FF
    32'h06_00_00_FF, 32'h06_00_01_03, 32'h06_00_02_3C, 32'h06_00_04_55,
    32'h06_00_04_AA, 32'h06_00_03_13, 32'h06_02_03_00, 32'h06_01_02_3C,
    // R6 invalid address 0x400 aliasing 0x000
    32'h06_00_00_00, 32'h06_00_01_04, 32'h06_00_04_55, 32'h06_00_04_AA,
    32'h06_00_03_13, 32'h06_01_03_16, 32'h06_00_01_00, 32'h06_01_02_FF,
    // R7 error survives a successful write, then clears on 0
    32'h07_00_03_16, 32'h07_00_02_5A, 32'h07_00_04_55, 32'h07_00_04_AA,
    32'h07_00_03_17, 32'h07_02_03_00, 32'h07_01_03_16, 32'h07_01_02_5A,
    32'h07_00_03_12, 32'h07_01_03_12,
    // R3 broken sequences; R2 foreign write after arming
    32'h03_00_02_77, 32'h03_00_04_55, 32'h03_00_02_77, 32'h03_00_04_AA,
    32'h03_00_03_13, 32'h03_01_03_12, 32'h03_00_04_55, 32'h03_00_04_AB,
    32'h03_00_03_13, 32'h03_01_03_12, 32'h02_00_04_55, 32'h02_00_04_AA,
    32'h02_00_00_00, 32'h02_00_03_13, 32'h02_01_03_12, 32'h03_01_02_5A
  };

  logic       clk, rst_n, bus_we, wr_prot, code_prot;
  logic [2:0] bus_sel;
  logic [7:0] bus_wdata, bus_rdata;
  int         ntests, nfail;
  bit         finished;

  ee_wr_guard #(.DEPTH(1024), .WRITE_CYCLES(WC), .PWRT_CYCLES(PW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wr_prot   (wr_prot),
    .code_prot (code_prot)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic bw(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk(input logic [2:0] s, input logic [7:0] exp, input int req, input string what);
    @(negedge clk);
    bus_sel = s;
    #1;
    ntests++;
    if (bus_rdata !== exp) begin
      nfail++;
      $display("FAIL R%0d %s: sel %0d got %02h expected %02h", req, what, s, bus_rdata, exp);
    end
  endtask

  task automatic poll(input int req);
    bit cleared = 1'b0;
    for (int k = 0; k < 4 * WC; k++) begin
      @(negedge clk);
      bus_sel = 3'd3;
      #1;
      if (bus_rdata[0] == 1'b0) begin
        cleared = 1'b1;
        break;
      end
    end
    ntests++;
    if (!cleared) begin
      nfail++;
      $display("FAIL R%0d start never cleared: got 1 expected 0", req);
    end
  endtask

  task automatic unlock();
    bw(3'd4, 8'h55);
    bw(3'd4, 8'hAA);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    ntests++;
    nfail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    summary();
  end

  initial begin
    int n;
    ntests = 0; nfail = 0; finished = 1'b0;
    rst_n = 1'b0; bus_we = 1'b0; bus_sel = 3'd0; bus_wdata = 8'h00;
    wr_prot = 1'b0; code_prot = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    chk(3'd3, 8'h00, 1, "control after reset");
    chk(3'd0, 8'h00, 1, "addr low after reset");
    chk(3'd1, 8'h00, 1, "addr high after reset");
    chk(3'd2, 8'h00, 1, "data read after reset");

    // R5 power-up lockout: full valid request inside the window
    bw(3'd3, 8'h12);
    unlock();
    bw(3'd3, 8'h13);
    chk(3'd3, 8'h12, 5, "start during lockout");
    repeat (PW + 10) @(posedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      case (v[23:16])
        8'h00:   bw(v[10:8], v[7:0]);
        8'h01:   chk(v[10:8], v[7:0], int'(v[31:24]), "table check");
        default: poll(int'(v[31:24]));
      endcase
    end

    // R8 exact write length, address 0x001
    bw(3'd0, 8'h01);
    bw(3'd2, 8'h42);
    unlock();
    bw(3'd3, 8'h13);
    bus_sel = 3'd3;
    #1;
    ntests++;
    if (bus_rdata[0] !== 1'b1) begin
      nfail++;
      $display("FAIL R8 start after launch: got %0b expected 1", bus_rdata[0]);
    end
    n = 0;
    for (int k = 0; k < 4 * WC; k++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      #1;
      if (bus_rdata[0] == 1'b0) break;
    end
    ntests++;
    if (n != WC) begin
      nfail++;
      $display("FAIL R8 busy length: got %0d expected %0d", n, WC);
    end
    chk(3'd2, 8'h42, 8, "byte at 0x001");
    bw(3'd0, 8'h00);

    // R4 enable bit clear
    bw(3'd3, 8'h10);
    unlock();
    bw(3'd3, 8'h11);
    chk(3'd3, 8'h10, 4, "start with enable clear");
    chk(3'd2, 8'h5A, 4, "array unchanged");
    bw(3'd3, 8'h12);

    // R11 region not selecting the array
    bw(3'd3, 8'h22);
    unlock();
    bw(3'd3, 8'h23);
    chk(3'd3, 8'h22, 11, "start with wrong region");
    chk(3'd2, 8'h00, 10, "read with wrong region");
    bw(3'd3, 8'h12);
    chk(3'd2, 8'h5A, 11, "array unchanged");

    // R9 address/data frozen during a write
    bw(3'd2, 8'h99);
    unlock();
    bw(3'd3, 8'h13);
    bw(3'd0, 8'h05);
    bw(3'd2, 8'h11);
    chk(3'd0, 8'h00, 9, "addr low during busy");
    poll(9);
    chk(3'd2, 8'h99, 9, "written byte");
    chk(3'd0, 8'h00, 9, "addr low after busy");

    // R6 write-protect input
    bw(3'd2, 8'h00);
    wr_prot = 1'b1;
    unlock();
    bw(3'd3, 8'h13);
    chk(3'd3, 8'h16, 6, "write-protected start");
    wr_prot = 1'b0;
    chk(3'd2, 8'h99, 6, "array unchanged");
    bw(3'd3, 8'h12);

    // R10 code protection
    code_prot = 1'b1;
    chk(3'd2, 8'h00, 10, "read under code protection");
    unlock();
    bw(3'd3, 8'h13);
    chk(3'd3, 8'h16, 6, "start under code protection");
    code_prot = 1'b0;
    chk(3'd2, 8'h99, 10, "read after protection released");

    summary();
  end
endmodule